// File: doc/BRIEF.md
# Erase-Sector Map and Boot-Sector Write Guard

This block sits between the command decoder of a 256K-word flash array and its program/erase engine. For every operation request it works out which of the four erase sectors the address falls in (the boot sector, two small parameter sectors and the large main sector). It then decides, one clock later, whether the operation may go ahead. A parameter selects whether the boot sector sits at the bottom or the top of the address space.

Protection comes from three places. The first is a sticky boot-sector lock: set by a command, it survives the ordinary reset and is cleared only by power-on initialisation. The second is a power-up hold-off timer. The third is the state of the chip-enable, output-enable and write-enable pins. A held high-voltage override flag lets an operation pass the lock, but only while the flag stays up. For a chip erase, the block reports as a mask which sectors the erase may touch. The block also produces the identification read data, which includes the lock state.

Top module: `sector_guard`

## Requirements
- R1: With the boot sector at the bottom, a word address maps to boot for 0x00000-0x01FFF, parameter A for 0x02000-0x02FFF, parameter B for 0x03000-0x03FFF and main for 0x04000-0x3FFFF. A granted sector erase reports exactly one mask bit: bit 0 for boot, bit 1 for parameter A, bit 2 for parameter B, bit 3 for main.
- R2: With TOP_BOOT=1 the map becomes boot 0x3E000-0x3FFFF, parameter A 0x3D000-0x3DFFF, parameter B 0x3C000-0x3CFFF and main 0x00000-0x3BFFF, using the same mask bit positions.
- R3: While the lock is set and the override is low, a program (op_kind 0) or sector erase (op_kind 1) aimed at the boot sector is denied. The same operations aimed at any other sector are granted. A granted program reports an all-zero mask.
- R4: A granted chip erase (op_kind 2) reports mask 4'b1111 when unlocked, or when locked with the override high. It reports 4'b1110 when locked with the override low. erase_mask is zero whenever op_grant is low.
- R5: With the override high at the request, a locked boot-sector operation is granted. If the override drops while that operation is still busy, op_grant and erase_mask go to zero on the next clock edge. Once the flag is low, the lock applies again.
- R6: The lock bit keeps its value through rst_n and is cleared only by por_n.
- R7: When id_mode is high, id_data returns MFR_CODE at address 0 and DEV_CODE at address 1. At the boot-sector base plus 2 it returns the lock state on bit 0 (1 = locked) with the other bits zero. Every other address returns zero. When id_mode is low, id_data is zero. id_data is registered and follows rd_addr after one clock edge.
- R8: All operations are denied until power_good has been high for INHIBIT_CYCLES consecutive clock edges. A low power_good restarts the count, and so does a reset.
- R9: An operation is denied unless ce_n=0, we_n=0 and oe_n=1 in the request cycle.
- R10: op_grant or op_deny is valid on the clock edge that samples op_start, and never both. op_deny is a one-cycle pulse. op_grant holds while op_busy is high and clears on the edge that samples op_busy low.
- R11: A granted lock command (op_kind 3) sets the lock on the edge that samples the request. The lock never rises without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; leaves the lock bit alone |
| por_n | input | 1 | Synchronous active-low power-on initialisation; clears everything including the lock |
| power_good | input | 1 | Supply-good indication that starts the hold-off count |
| ce_n | input | 1 | Chip-enable pin state, active low |
| oe_n | input | 1 | Output-enable pin state, active low |
| we_n | input | 1 | Write-enable pin state, active low |
| op_start | input | 1 | One-cycle operation request from the command decoder |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 lock command |
| op_addr | input | ADDR_W | Word address of the requested operation |
| op_busy | input | 1 | High while the engine still runs the granted operation |
| hv_override | input | 1 | High-voltage override flag that bypasses the lock |
| id_mode | input | 1 | Identification-mode flag |
| rd_addr | input | ADDR_W | Read word address for the identification path |
| op_grant | output | 1 | Operation permitted; held while it runs |
| op_deny | output | 1 | One-cycle refusal pulse |
| erase_mask | output | 4 | Sectors the granted operation may erase |
| id_data | output | 16 | Identification read data |

## Verification
The grant/deny decision and erase_mask are due on the first rising edge after op_start is driven. The refusal pulse must be gone one edge later. The grant must clear on the edge that samples op_busy low, or the override low. id_data is due one edge after rd_addr changes. The power-up hold-off ends after exactly INHIBIT_CYCLES edges with power_good high. The bench drives every input on the falling edge and samples outputs 1 ns after the rising edge where each result is due. It also re-samples one edge later to catch values that linger or are dropped early.

// File: rtl/sector_guard_pkg.sv
package sector_guard_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CHIP   = 2'd2,
    OP_LOCK   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    SEC_BOOT = 2'd0,
    SEC_PARA = 2'd1,
    SEC_PARB = 2'd2,
    SEC_MAIN = 2'd3
  } sector_e;

  // First word of the boot sector for the chosen layout.
  function automatic logic [31:0] boot_base(input int addr_w, input int boot_bits,
                                            input bit top);
    logic [31:0] span;
    span = 32'd1 << addr_w;
    return top ? (span - (32'd1 << boot_bits)) : 32'd0;
  endfunction

  // Sector lookup: the boot sector spans 2**boot_bits words and each
  // parameter sector half of that, both parameter sectors adjacent to boot.
  function automatic sector_e sector_of(input logic [31:0] addr, input int addr_w,
                                        input int boot_bits, input bit top);
    logic [31:0] boot_idx, par_idx, boot_last, par_cnt;
    boot_idx  = addr >> boot_bits;
    par_idx   = addr >> (boot_bits - 1);
    boot_last = (32'd1 << (addr_w - boot_bits)) - 32'd1;
    par_cnt   = 32'd1 << (addr_w - boot_bits + 1);
    if (top) begin
      if (boot_idx == boot_last)            return SEC_BOOT;
      else if (par_idx == par_cnt - 32'd3)  return SEC_PARA;
      else if (par_idx == par_cnt - 32'd4)  return SEC_PARB;
      else                                  return SEC_MAIN;
    end else begin
      if (boot_idx == 32'd0)                return SEC_BOOT;
      else if (par_idx == 32'd2)            return SEC_PARA;
      else if (par_idx == 32'd3)            return SEC_PARB;
      else                                  return SEC_MAIN;
    end
  endfunction

endpackage

// File: rtl/sg_power_timer.sv
module sg_power_timer #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_all,
  input  logic power_good,
  output logic ready
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign ready = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst_all || !power_good) cnt_q <= '0;
    else if (!ready)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sg_lock_reg.sv
module sg_lock_reg (
  input  logic clk,
  input  logic por_n,
  input  logic set_lock,
  output logic lock_q
);
  // Models a nonvolatile bit: only power-on initialisation clears it.
  always_ff @(posedge clk) begin
    if (!por_n)        lock_q <= 1'b0;
    else if (set_lock) lock_q <= 1'b1;
  end
endmodule

// File: rtl/sg_access_check.sv
module sg_access_check
  import sector_guard_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BOOT_BITS = 13,
  parameter bit TOP_BOOT  = 1'b0
) (
  input  op_kind_e          kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  input  logic              hv_override,
  input  logic              pwr_ready,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic              permit,
  output logic [3:0]        new_mask,
  output logic              uses_ovr,
  output logic              tgt_boot
);
  sector_e    sec;
  logic       base_ok;
  logic       locked_out;
  logic [3:0] sec_onehot;

  assign sec        = sector_of(32'(addr), ADDR_W, BOOT_BITS, TOP_BOOT);
  assign tgt_boot   = (sec == SEC_BOOT);
  assign base_ok    = pwr_ready && !ce_n && !we_n && oe_n;
  assign locked_out = lock && !hv_override;

  for (genvar s = 0; s < 4; s++) begin : g_onehot
    assign sec_onehot[s] = (sec == sector_e'(s));
  end

  always_comb begin
    permit   = base_ok;
    new_mask = 4'b0000;
    uses_ovr = 1'b0;
    unique case (kind)
      OP_PROG: begin
        permit   = base_ok && !(tgt_boot && locked_out);
        uses_ovr = tgt_boot && lock;
      end
      OP_SERASE: begin
        permit   = base_ok && !(tgt_boot && locked_out);
        new_mask = sec_onehot;
        uses_ovr = tgt_boot && lock;
      end
      OP_CHIP: begin
        new_mask = locked_out ? 4'b1110 : 4'b1111;
        uses_ovr = lock && hv_override;
      end
      OP_LOCK: begin
        permit = base_ok;
      end
      default: permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/sg_id_read.sv
module sg_id_read
  import sector_guard_pkg::*;
#(
  parameter int          ADDR_W    = 18,
  parameter int          BOOT_BITS = 13,
  parameter bit          TOP_BOOT  = 1'b0,
  parameter logic [15:0] MFR_CODE  = 16'h00A5,
  parameter logic [15:0] DEV_CODE  = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst_all,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              lock,
  output logic [15:0]       id_data
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR =
    ADDR_W'(boot_base(ADDR_W, BOOT_BITS, TOP_BOOT) + 32'd2);

  always_ff @(posedge clk) begin
    if (rst_all || !id_mode)             id_data <= 16'h0000;
    else if (rd_addr == ADDR_W'(0))      id_data <= MFR_CODE;
    else if (rd_addr == ADDR_W'(1))      id_data <= DEV_CODE;
    else if (rd_addr == LOCK_ADDR)       id_data <= {15'h0000, lock};
    else                                 id_data <= 16'h0000;
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sector_guard_pkg::*;
#(
  parameter int          ADDR_W         = 18,
  parameter int          BOOT_BITS      = 13,
  parameter bit          TOP_BOOT       = 1'b0,
  parameter int          INHIBIT_CYCLES = 1000000,
  parameter logic [15:0] MFR_CODE       = 16'h00A5,
  parameter logic [15:0] DEV_CODE       = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              power_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_busy,
  input  logic              hv_override,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              op_grant,
  output logic              op_deny,
  output logic [3:0]        erase_mask,
  output logic [15:0]       id_data
);
  logic       rst_all;
  logic       pwr_ready;
  logic       lock_q;
  logic       set_lock;
  logic       permit;
  logic [3:0] new_mask;
  logic       uses_ovr;
  logic       tgt_boot;
  logic       need_ovr_q;
  logic       accept;
  logic       release_op;

  assign rst_all = !rst_n || !por_n;

  sg_power_timer #(.LIMIT(INHIBIT_CYCLES)) u_timer (
    .clk        (clk),
    .rst_all    (rst_all),
    .power_good (power_good),
    .ready      (pwr_ready)
  );

  sg_access_check #(.ADDR_W(ADDR_W), .BOOT_BITS(BOOT_BITS), .TOP_BOOT(TOP_BOOT)) u_check (
    .kind        (op_kind_e'(op_kind)),
    .addr        (op_addr),
    .lock        (lock_q),
    .hv_override (hv_override),
    .pwr_ready   (pwr_ready),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .permit      (permit),
    .new_mask    (new_mask),
    .uses_ovr    (uses_ovr),
    .tgt_boot    (tgt_boot)
  );

  assign accept     = op_start && permit;
  assign set_lock   = accept && rst_n && (op_kind == OP_LOCK);
  assign release_op = op_grant && (!op_busy || (need_ovr_q && !hv_override));

  sg_lock_reg u_lock (
    .clk      (clk),
    .por_n    (por_n),
    .set_lock (set_lock),
    .lock_q   (lock_q)
  );

  always_ff @(posedge clk) begin
    if (rst_all) begin
      op_grant   <= 1'b0;
      op_deny    <= 1'b0;
      erase_mask <= 4'b0000;
      need_ovr_q <= 1'b0;
    end else begin
      op_deny <= op_start && !permit;
      if (accept) begin
        op_grant   <= 1'b1;
        erase_mask <= new_mask;
        need_ovr_q <= uses_ovr;
      end else if (op_start || release_op) begin
        op_grant   <= 1'b0;
        erase_mask <= 4'b0000;
        need_ovr_q <= 1'b0;
      end
    end
  end

  sg_id_read #(
    .ADDR_W(ADDR_W), .BOOT_BITS(BOOT_BITS), .TOP_BOOT(TOP_BOOT),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_id (
    .clk     (clk),
    .rst_all (rst_all),
    .id_mode (id_mode),
    .rd_addr (rd_addr),
    .lock    (lock_q),
    .id_data (id_data)
  );
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_n,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic       hv_override,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       op_grant,
  input logic       op_deny,
  input logic [3:0] erase_mask,
  input logic       lock_q,
  input logic       pwr_ready,
  input logic       tgt_boot
);
  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(op_grant && op_deny)); // R10

  AST_DENY_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    op_deny && !op_start |=> !op_deny); // R10

  AST_BOOT_PROTECT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    op_start && lock_q && !hv_override && tgt_boot && (op_kind == 2'd0 || op_kind == 2'd1)
    |=> !op_grant && op_deny); // R3

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !op_grant |-> erase_mask == 4'b0000); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q); // R6

  AST_LOCK_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(lock_q) |-> $past(op_start && op_kind == 2'd3)); // R11

  AST_POWER_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    op_start && !pwr_ready |=> !op_grant); // R8

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    op_start && (ce_n || we_n || !oe_n) |=> !op_grant); // R9

  AST_SECTOR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    op_start && op_kind == 2'd1 |=> op_deny || $onehot0(erase_mask)); // R1
endmodule

bind sector_guard sector_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_n       (por_n),
  .op_start    (op_start),
  .op_kind     (op_kind),
  .hv_override (hv_override),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .op_grant    (op_grant),
  .op_deny     (op_deny),
  .erase_mask  (erase_mask),
  .lock_q      (lock_q),
  .pwr_ready   (pwr_ready),
  .tgt_boot    (tgt_boot)
);

// File: tb/sector_guard_tb.sv
`timescale 1ns/1ps
module sector_guard_tb;
  localparam int AW   = 18;
  localparam int HOLD = 20;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h5A3C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, por_n = 1'b0, power_good = 1'b0;
  logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0;
  logic op_start = 1'b0, op_busy = 1'b0, hv_override = 1'b0, id_mode = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0, rd_addr = '0;

  logic grant_b, deny_b, grant_t, deny_t;
  logic [3:0] mask_b, mask_t;
  logic [15:0] id_b, id_t;

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;

  sector_guard #(.ADDR_W(AW), .TOP_BOOT(1'b0), .INHIBIT_CYCLES(HOLD),
                 .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .power_good(power_good),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_busy(op_busy), .hv_override(hv_override),
    .id_mode(id_mode), .rd_addr(rd_addr), .op_grant(grant_b), .op_deny(deny_b),
    .erase_mask(mask_b), .id_data(id_b));

  sector_guard #(.ADDR_W(AW), .TOP_BOOT(1'b1), .INHIBIT_CYCLES(HOLD),
                 .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut_top (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .power_good(power_good),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_busy(op_busy), .hv_override(hv_override),
    .id_mode(id_mode), .rd_addr(rd_addr), .op_grant(grant_t), .op_deny(deny_t),
    .erase_mask(mask_t), .id_data(id_t));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input bit top, input logic [31:0] b, input logic [31:0] t);
    return top ? t : b;
  endfunction

  // Full request: decision and mask on the first edge, deny gone and grant
  // held one edge later (R10), grant cleared on the edge that sees busy low.
  task automatic do_op(input string tag, input bit top, input logic [1:0] kind,
                       input logic [AW-1:0] addr, input bit exp_g, input logic [3:0] exp_m);
    @(negedge clk);
    op_kind = kind; op_addr = addr; op_start = 1'b1; op_busy = 1'b1;
    @(posedge clk); #1;
    chk({tag, " grant"}, pick(top, grant_b, grant_t), exp_g);
    chk({tag, " deny"},  pick(top, deny_b, deny_t), !exp_g);
    chk({tag, " mask"},  pick(top, mask_b, mask_t), exp_g ? exp_m : 4'b0000);
    @(negedge clk); op_start = 1'b0;
    @(posedge clk); #1;
    chk({tag, " R10 deny pulse"}, pick(top, deny_b, deny_t), 1'b0);
    chk({tag, " R10 grant held"}, pick(top, grant_b, grant_t), exp_g);
    @(negedge clk); op_busy = 1'b0;
    @(posedge clk); #1;
    chk({tag, " R10 grant release"}, pick(top, grant_b, grant_t), 1'b0);
  endtask

  task automatic id_rd(input string tag, input bit top, input logic [AW-1:0] addr,
                       input logic [15:0] exp);
    @(negedge clk); rd_addr = addr;
    @(posedge clk); #1;
    chk(tag, pick(top, id_b, id_t), exp);
  endtask

  task automatic wait_ready();
    repeat (HOLD + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(posedge clk); #1;
    chk("reset grant", grant_b, 1'b0);
    chk("reset deny", deny_b, 1'b0);
    chk("reset mask", mask_b, 4'b0000);
    chk("R7 reset id_data", id_b, 16'h0000);
  endtask

  task automatic t_power();
    @(negedge clk); power_good = 1'b1;
    repeat (3) @(negedge clk);
    do_op("R8 early", 1'b0, 2'd0, 18'h10000, 1'b0, 4'b0000);
    wait_ready();
    do_op("R8 after hold", 1'b0, 2'd0, 18'h10000, 1'b1, 4'b0000);
    @(negedge clk); power_good = 1'b0;
    @(negedge clk); power_good = 1'b1;
    do_op("R8 restart", 1'b0, 2'd0, 18'h10000, 1'b0, 4'b0000);
    wait_ready();
  endtask

  task automatic t_pins();
    ce_n = 1'b1;
    do_op("R9 ce high", 1'b0, 2'd0, 18'h10000, 1'b0, 4'b0000);
    ce_n = 1'b0; oe_n = 1'b0;
    do_op("R9 oe low", 1'b0, 2'd0, 18'h10000, 1'b0, 4'b0000);
    oe_n = 1'b1; we_n = 1'b1;
    do_op("R9 we high", 1'b0, 2'd0, 18'h10000, 1'b0, 4'b0000);
    we_n = 1'b0;
  endtask

  task automatic t_map_bottom();
    do_op("R1 0x00000", 1'b0, 2'd1, 18'h00000, 1'b1, 4'b0001);
    do_op("R1 0x01FFF", 1'b0, 2'd1, 18'h01FFF, 1'b1, 4'b0001);
    do_op("R1 0x02000", 1'b0, 2'd1, 18'h02000, 1'b1, 4'b0010);
    do_op("R1 0x02FFF", 1'b0, 2'd1, 18'h02FFF, 1'b1, 4'b0010);
    do_op("R1 0x03000", 1'b0, 2'd1, 18'h03000, 1'b1, 4'b0100);
    do_op("R1 0x03FFF", 1'b0, 2'd1, 18'h03FFF, 1'b1, 4'b0100);
    do_op("R1 0x04000", 1'b0, 2'd1, 18'h04000, 1'b1, 4'b1000);
    do_op("R1 0x3FFFF", 1'b0, 2'd1, 18'h3FFFF, 1'b1, 4'b1000);
  endtask

  task automatic t_map_top();
    do_op("R2 0x3E000", 1'b1, 2'd1, 18'h3E000, 1'b1, 4'b0001);
    do_op("R2 0x3FFFF", 1'b1, 2'd1, 18'h3FFFF, 1'b1, 4'b0001);
    do_op("R2 0x3DFFF", 1'b1, 2'd1, 18'h3DFFF, 1'b1, 4'b0010);
    do_op("R2 0x3D000", 1'b1, 2'd1, 18'h3D000, 1'b1, 4'b0010);
    do_op("R2 0x3C000", 1'b1, 2'd1, 18'h3C000, 1'b1, 4'b0100);
    do_op("R2 0x3BFFF", 1'b1, 2'd1, 18'h3BFFF, 1'b1, 4'b1000);
    do_op("R2 0x00000", 1'b1, 2'd1, 18'h00000, 1'b1, 4'b1000);
  endtask

  task automatic t_id_unlocked();
    id_mode = 1'b1;
    id_rd("R7 mfr", 1'b0, 18'h00000, MFR);
    id_rd("R7 dev", 1'b0, 18'h00001, DEV);
    id_rd("R7 lock clear", 1'b0, 18'h00002, 16'h0000);
    id_rd("R7 other addr", 1'b0, 18'h00005, 16'h0000);
    id_rd("R7 top lock clear", 1'b1, 18'h3E002, 16'h0000);
    id_mode = 1'b0;
    id_rd("R7 mode off", 1'b0, 18'h00000, 16'h0000);
  endtask

  task automatic t_lock();
    do_op("R11 lock cmd", 1'b0, 2'd3, 18'h00000, 1'b1, 4'b0000);
    id_mode = 1'b1;
    id_rd("R11 lock bit", 1'b0, 18'h00002, 16'h0001);
    id_rd("R7 top lock bit", 1'b1, 18'h3E002, 16'h0001);
    id_rd("R7 top base+2 of bottom", 1'b1, 18'h00002, 16'h0000);
    id_mode = 1'b0;
  endtask

  task automatic t_locked_refusal();
    do_op("R3 prog boot", 1'b0, 2'd0, 18'h00010, 1'b0, 4'b0000);
    do_op("R3 erase boot", 1'b0, 2'd1, 18'h01000, 1'b0, 4'b0000);
    do_op("R3 top erase boot", 1'b1, 2'd1, 18'h3F000, 1'b0, 4'b0000);
    do_op("R3 prog main", 1'b0, 2'd0, 18'h05000, 1'b1, 4'b0000);
    do_op("R3 erase main", 1'b0, 2'd1, 18'h20000, 1'b1, 4'b1000);
    do_op("R3 erase param", 1'b0, 2'd1, 18'h02100, 1'b1, 4'b0010);
  endtask

  task automatic t_chip();
    do_op("R4 chip locked", 1'b0, 2'd2, 18'h05555, 1'b1, 4'b1110);
    hv_override = 1'b1;
    do_op("R4 chip override", 1'b0, 2'd2, 18'h05555, 1'b1, 4'b1111);
    hv_override = 1'b0;
  endtask

  task automatic t_override();
    @(negedge clk); hv_override = 1'b1;
    do_op("R5 override erase boot", 1'b0, 2'd1, 18'h00000, 1'b1, 4'b0001);
    @(negedge clk);
    op_kind = 2'd0; op_addr = 18'h00100; op_start = 1'b1; op_busy = 1'b1;
    @(negedge clk); op_start = 1'b0;
    @(posedge clk); #1;
    chk("R5 grant during override", grant_b, 1'b1);
    @(negedge clk); hv_override = 1'b0;
    @(posedge clk); #1;
    chk("R5 revoked grant", grant_b, 1'b0);
    chk("R5 revoked mask", mask_b, 4'b0000);
    @(negedge clk); op_busy = 1'b0;
    do_op("R5 lock back", 1'b0, 2'd0, 18'h00100, 1'b0, 4'b0000);
  endtask

  task automatic t_sticky();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    id_mode = 1'b1;
    id_rd("R6 lock after rst_n", 1'b0, 18'h00002, 16'h0001);
    do_op("R8 hold after rst_n", 1'b0, 2'd0, 18'h10000, 1'b0, 4'b0000);
    wait_ready();
    do_op("R6 still refused", 1'b0, 2'd1, 18'h00000, 1'b0, 4'b0000);
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    id_rd("R6 lock cleared by por_n", 1'b0, 18'h00002, 16'h0000);
    wait_ready();
    do_op("R6 boot open again", 1'b0, 2'd1, 18'h00000, 1'b1, 4'b0001);
    do_op("R4 chip unlocked", 1'b0, 2'd2, 18'h05555, 1'b1, 4'b1111);
    id_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_power();
    t_pins();
    t_map_bottom();
    t_map_top();
    t_id_unlocked();
    t_chip_pre: begin
      do_op("R4 chip unlocked first", 1'b0, 2'd2, 18'h05555, 1'b1, 4'b1111);
    end
    t_lock();
    t_locked_refusal();
    t_chip();
    t_override();
    t_sticky();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule